// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Override

This block is an eight-pin general-purpose I/O port. Each pin has an output data latch and a direction latch. Software loads both through a small register bus. Any pin can be handed to an on-chip peripheral. While a pin is handed over, the peripheral supplies the pin's output value and decides whether the pin drives or listens. Some peripherals make the pin drive, and others make it listen.

The pad is modelled as three separate signals: an output value, an output enable and an input, so no tri-state net is needed. Pad inputs pass through a two-flop synchroniser. The synchronised value then feeds two places: the port read path, and a set of per-pin inputs returned to the peripherals.

The direction register reads back the effective direction, with any overrides applied. A read-modify-write of that register while a peripheral owns a pin therefore stores the override into the latch.

Top module: `gpio_override_port`

## Requirements
- R1: After reset, every direction latch bit is 1 (input) and the data latch is 0. As a result, a read of address 1 returns all ones, `pad_oe` is 0 and `pad_out` is 0.
- R2: A write with `bus_addr`=0 and `bus_we`=1 loads `bus_wdata` into the data latch at the rising edge. On a pin without a peripheral select, `pad_out` then shows the latch bit. This holds whatever the pin's direction.
- R3: A write with `bus_addr`=1 loads the direction latch. On a pin without a select, a bit of 0 sets `pad_oe`=1 and a bit of 1 sets `pad_oe`=0.
- R4: When `periph_sel` bit i is 1, `pad_out` bit i is taken from `periph_dout`, not from the data latch.
- R5: When `periph_sel` bit i is 1, `periph_oe` bit i sets the direction: a value of 1 forces an output (`pad_oe`=1) and a value of 0 forces an input (`pad_oe`=0). When the select bit is 0, `periph_oe` has no effect.
- R6: A read of address 0 returns the pad input after two-flop synchronisation, not the data latch. A change on `pad_in` appears on `bus_rdata` after the second rising edge that follows it.
- R7: A read of address 1 returns the effective direction, with 1 meaning input. On pins with the select bit set, that bit is the inverse of `periph_oe`.
- R8: `periph_din` always carries the synchronised pad input, whatever the state of `periph_sel`.
- R9: With `bus_we`=0, neither latch changes. A write to one address leaves the other latch unchanged.
- R10: Suppose the direction register is read while a peripheral forces a pin to output, and the value read is written back. The stored direction bit then becomes 0, so the pin keeps driving after the select is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 = data, 1 = direction |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| periph_sel | input | 8 | Per-pin handover to a peripheral |
| periph_dout | input | 8 | Peripheral output value per pin |
| periph_oe | input | 8 | Peripheral drive request per pin (1 = drive) |
| periph_din | output | 8 | Synchronised pad input returned to the peripherals |
| pad_in | input | 8 | Raw pad input |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad driver enable (1 = drive) |

## Verification
A latch write is visible on `pad_out`, `pad_oe` and the direction read-back one rising edge after the strobe. A change on `pad_in` reaches `bus_rdata` and `periph_din` after the second rising edge. Changes on the select, `periph_oe` and `periph_dout` reach the pads in the same cycle, through combinational logic. The bench changes inputs on falling edges and samples half a cycle later. For the synchroniser, it samples both after the first edge, where the old value must still show, and after the second edge, where the new value must show.

// File: rtl/gpio_override_port.sv
module gpio_override_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_addr,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] periph_sel,
  input  logic [W-1:0] periph_dout,
  input  logic [W-1:0] periph_oe,
  output logic [W-1:0] periph_din,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);

  logic [W-1:0] data_q, dir_q, meta_q, sync_q;
  logic [W-1:0] eff_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '1;
    end else if (bus_we) begin
      if (bus_addr) dir_q  <= bus_wdata;
      else          data_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  assign eff_dir    = (periph_sel & ~periph_oe) | (~periph_sel & dir_q);
  assign pad_out    = (periph_sel & periph_dout) | (~periph_sel & data_q);
  assign pad_oe     = ~eff_dir;
  assign periph_din = sync_q;
  assign bus_rdata  = bus_addr ? eff_dir : sync_q;

endmodule

module gpio_override_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_addr,
  input logic         bus_we,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] periph_sel,
  input logic [W-1:0] periph_oe,
  input logic [W-1:0] periph_din,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] data_q,
  input logic [W-1:0] sync_q
);

  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr) |=> dir_q == $past(bus_wdata));

  a_r2_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_addr) |=> data_q == $past(bus_wdata));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(dir_q) && $stable(data_q)));

  a_r5_free_pins: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ ~dir_q) & ~periph_sel) == '0);

  a_r6_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 2'd2) |-> sync_q == $past(pad_in, 2));

  a_r8_periph_in: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> periph_din == bus_rdata);

endmodule

bind gpio_override_port gpio_override_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_sel(periph_sel),
  .periph_oe(periph_oe), .periph_din(periph_din), .pad_in(pad_in),
  .pad_oe(pad_oe), .dir_q(dir_q), .data_q(data_q), .sync_q(sync_q)
);

// File: tb/test_gpio_override_port.sv
module test_gpio_override_port;
  logic       clk = 0, rst_n = 0, bus_addr = 0, bus_we = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, periph_sel = 0, periph_dout = 0, periph_oe = 0;
  logic [7:0] periph_din, pad_in = 0, pad_out, pad_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_override_port i_gpio_override_port (.*);

  // dir, data, sel, poe, pdo, exp_out, exp_oe, exp_rd
  localparam logic [63:0] VEC [5] = '{
    {8'h00, 8'hA5, 8'h00, 8'h00, 8'hFF, 8'hA5, 8'hFF, 8'h00},
    {8'hFF, 8'hA5, 8'h00, 8'h00, 8'h00, 8'hA5, 8'h00, 8'hFF},
    {8'hF0, 8'h3C, 8'h0F, 8'hF5, 8'h99, 8'h39, 8'h05, 8'hFA},
    {8'h0F, 8'h00, 8'hF0, 8'hA0, 8'hC3, 8'hC0, 8'hA0, 8'h5F},
    {8'hAA, 8'h55, 8'hFF, 8'h00, 8'h12, 8'h12, 8'h00, 8'hFF}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(1, v); chk("R1 dir reset", v, 8'hFF);
    chk("R1 oe reset", pad_oe, 8'h00);
    chk("R1 out reset", pad_out, 8'h00);

    for (int k = 0; k < 5; k++) begin
      wr(1, VEC[k][63:56]);
      wr(0, VEC[k][55:48]);
      periph_sel = VEC[k][47:40]; periph_oe = VEC[k][39:32]; periph_dout = VEC[k][31:24];
      #1;
      chk("R2 R4 pad_out", pad_out, VEC[k][23:16]);
      chk("R3 R5 pad_oe", pad_oe, VEC[k][15:8]);
      rd(1, v); chk("R7 dir readback", v, VEC[k][7:0]);
    end

    // R9: no write without strobe, cross-address isolation
    periph_sel = 0; periph_oe = 0;
    wr(1, 8'h33); wr(0, 8'hC6);
    @(negedge clk); bus_addr = 1; bus_wdata = 8'h00; bus_we = 0;
    @(negedge clk);
    rd(1, v); chk("R9 dir held", v, 8'h33);
    chk("R9 data held", pad_out, 8'hC6);
    wr(0, 8'h0F);
    rd(1, v); chk("R9 dir untouched by data write", v, 8'h33);

    // R6 / R8: synchroniser latency, read is pin not latch
    periph_sel = 8'hFF; periph_oe = 8'h00;
    @(negedge clk); pad_in = 8'h5A;
    @(negedge clk);
    rd(0, v); chk("R6 after one edge", v, 8'h00);
    @(negedge clk);
    rd(0, v); chk("R6 after two edges", v, 8'h5A);
    chk("R8 periph_din selected", periph_din, 8'h5A);
    periph_sel = 0; #1;
    chk("R8 periph_din unselected", periph_din, 8'h5A);

    // R10: read-modify-write hazard
    wr(1, 8'hFF);
    periph_sel = 8'h01; periph_oe = 8'h01;
    rd(1, v); chk("R10 override read", v, 8'hFE);
    wr(1, v);
    periph_sel = 0; periph_oe = 0; #1;
    rd(1, v); chk("R10 latch captured override", v, 8'hFE);
    chk("R10 pin still drives", pad_oe, 8'h01);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule